// File: doc/BRIEF.md
# Oscillator Start-up Sequencer

This block decides when the main clock of a chip may be trusted. Software programs a 16-bit control word through a one-cycle write strobe. The word turns the main oscillator on or off, selects an external clock that replaces the oscillator, and sets an 8-bit start-up count. The analog oscillator is not part of the block. It is represented only by the `osc_en_o` output.

The block also receives a slow reference clock. It arrives as a one-cycle strobe, already synchronised into the register clock domain. When the oscillator is switched on, the block waits a number of slow-clock strobes equal to eight times the programmed count, and then raises `stable_o`. If the external clock is selected while the oscillator is off, the main clock counts as usable at once.

A write that asks for the oscillator and the external clock together is rejected as a whole, and a sticky error flag is raised. None of the ports carries a data stream. Every pin is a plain level or a plain strobe, and there is no back-pressure.

Top module: `osc_startup_seq`

## Requirements
- R1: Once reset has been released, `osc_en_o`, `bypass_o`, `stable_o` and `err_o` are all 0.
- R2: A legal write copies bit 0 of `wr_data_i` to `osc_en_o` and bit 1 to `bypass_o`. Both outputs are visible in the cycle after the write.
- R3: When a write takes the enable from 0 to 1, the timer is loaded with eight times bits 15..8 of that write. `stable_o` rises in the cycle after the N-th later slow strobe, where N is that product. A strobe that arrives in the same cycle as the loading write is not counted.
- R4: If the start-up count is 0, `stable_o` rises in the cycle after the first slow strobe that follows the enabling write.
- R5: While the enable stays 1, `stable_o` does not fall once it has risen. A further write that keeps bit 0 at 1 does not restart the wait.
- R6: A legal write with bit 0 equal to 0 clears `stable_o` in the cycle after the write, unless that same write sets bit 1.
- R7: A write with bit 0 = 0 and bit 1 = 1 makes `stable_o` high in the cycle after the write, with no wait.
- R8: A write with both bit 0 and bit 1 set changes neither `osc_en_o` nor `bypass_o`, and does not touch a wait that is in progress. It sets `err_o`.
- R9: Once `err_o` is set, it stays at 1 until reset.
- R10: When no slow strobe arrives, a wait in progress does not advance, so `stable_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | One-cycle write strobe for the control word |
| wr_data_i | input | 16 | Control word: bit 0 enable, bit 1 external clock, bits 15..8 start-up count |
| slow_tick_i | input | 1 | One-cycle strobe for each slow reference clock period |
| osc_en_o | output | 1 | Enable to the oscillator |
| bypass_o | output | 1 | External clock selected in place of the oscillator |
| stable_o | output | 1 | Main clock usable |
| err_o | output | 1 | Sticky flag: a write asked for enable and external clock together |

## Verification
A control write and a slow strobe can land in the same cycle. This matters most for the write that loads the timer, where the strobe has to be discarded, and for the write that disables the oscillator, where clearing the flag must take precedence over counting. The bench forces both collisions in directed steps. In the random phase, writes and strobes are issued independently, so they also meet at arbitrary points of a wait. Every cycle is judged against a reference model in the bench. The model applies the kill, load and count priorities taken from R3, R6 and R8.

// File: rtl/oscseq_pkg.sv
package oscseq_pkg;
  // Field positions of the control word; software encodes against these.
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned EN_POS  = 0;
  localparam int unsigned BYP_POS = 1;
  localparam int unsigned CNT_LSB = 8;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned SCALE_SH = 3;  // start-up count is scaled by 2**SCALE_SH

  typedef enum logic [1:0] {
    TS_OFF   = 2'd0,
    TS_WAIT  = 2'd1,
    TS_READY = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/oscseq_ctrl.sv
module oscseq_ctrl #(
  parameter int unsigned CTRL_W  = oscseq_pkg::CTRL_W,
  parameter int unsigned EN_POS  = oscseq_pkg::EN_POS,
  parameter int unsigned BYP_POS = oscseq_pkg::BYP_POS,
  parameter int unsigned CNT_LSB = oscseq_pkg::CNT_LSB,
  parameter int unsigned CNT_W   = oscseq_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              en_o,
  output logic              byp_o,
  output logic              err_o,
  output logic              load_o,
  output logic              kill_o,
  output logic [CNT_W-1:0]  load_cnt_o
);
  localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;

  logic w_en, w_byp, w_bad, w_ok;
  logic en_q, byp_q, err_q;
  logic unused_bits;

  assign w_en  = wr_data_i[EN_POS];
  assign w_byp = wr_data_i[BYP_POS];
  assign w_bad = w_en & w_byp;
  assign w_ok  = wr_en_i & ~w_bad;

  // Rising enable loads the timer; any legal disable kills it.
  assign load_o     = w_ok & w_en & ~en_q;
  assign kill_o     = w_ok & ~w_en;
  assign load_cnt_o = wr_data_i[CNT_MSB:CNT_LSB];

  assign unused_bits = ^wr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      byp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (w_ok) begin
        en_q  <= w_en;
        byp_q <= w_byp;
      end
      if (wr_en_i && w_bad) begin
        err_q <= 1'b1;
      end
    end
  end

  assign en_o  = en_q;
  assign byp_o = byp_q;
  assign err_o = err_q;
endmodule

// File: rtl/oscseq_timer.sv
module oscseq_timer #(
  parameter int unsigned CNT_W    = oscseq_pkg::CNT_W,
  parameter int unsigned SCALE_SH = oscseq_pkg::SCALE_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             tick_i,
  output logic             ready_o
);
  import oscseq_pkg::*;

  localparam int unsigned TMR_W = CNT_W + SCALE_SH;
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  tmr_state_e       state_q;
  logic [TMR_W-1:0] left_q;
  logic [TMR_W-1:0] load_val;

  assign load_val = {load_cnt_i, {SCALE_SH{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TS_OFF;
      left_q  <= '0;
    end else if (kill_i) begin
      state_q <= TS_OFF;
      left_q  <= '0;
    end else if (load_i) begin
      state_q <= TS_WAIT;
      left_q  <= load_val;
    end else if (state_q == TS_WAIT && tick_i) begin
      if (left_q <= ONE) begin
        state_q <= TS_READY;
      end
      if (left_q != '0) begin
        left_q <= left_q - ONE;
      end
    end
  end

  assign ready_o = (state_q == TS_READY);
endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq #(
  parameter int unsigned CTRL_W   = oscseq_pkg::CTRL_W,
  parameter int unsigned CNT_W    = oscseq_pkg::CNT_W,
  parameter int unsigned SCALE_SH = oscseq_pkg::SCALE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              slow_tick_i,
  output logic              osc_en_o,
  output logic              bypass_o,
  output logic              stable_o,
  output logic              err_o
);
  logic             load, kill, ready, byp;
  logic [CNT_W-1:0] load_cnt;

  oscseq_ctrl #(
    .CTRL_W (CTRL_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .en_o       (osc_en_o),
    .byp_o      (byp),
    .err_o      (err_o),
    .load_o     (load),
    .kill_o     (kill),
    .load_cnt_o (load_cnt)
  );

  oscseq_timer #(
    .CNT_W    (CNT_W),
    .SCALE_SH (SCALE_SH)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .kill_i     (kill),
    .load_cnt_i (load_cnt),
    .tick_i     (slow_tick_i),
    .ready_o    (ready)
  );

  assign bypass_o = byp;
  // External clock needs no settling; the oscillator path waits for the timer.
  assign stable_o = ready | byp;
endmodule

// File: rtl/osc_startup_seq_chk.sv
module osc_startup_seq_chk #(
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [CTRL_W-1:0] wr_data_i,
  input logic              slow_tick_i,
  input logic              osc_en_o,
  input logic              bypass_o,
  input logic              stable_o,
  input logic              err_o
);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R8
  bad_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[0] && wr_data_i[1]) |=> (err_o && $stable(bypass_o) && $stable(osc_en_o)));

  // R8
  no_en_with_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en_o && bypass_o));

  // R3
  wait_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en_o) |-> !stable_o);

  // R6
  off_means_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en_o && !bypass_o) |-> !stable_o);

  // R5
  stable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o && osc_en_o) |=> (stable_o || !osc_en_o));

  // R10
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !slow_tick_i) |=> $stable(stable_o));
endmodule

bind osc_startup_seq osc_startup_seq_chk #(.CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/osc_startup_seq_tb.sv
`timescale 1ns/1ps
module osc_startup_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        slow_tick_i = 1'b0;
  logic        osc_en_o, bypass_o, stable_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_en, m_byp, m_err, m_wait, m_rdy;
  int m_left;

  always #2.5 clk = ~clk;

  osc_startup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .slow_tick_i(slow_tick_i), .osc_en_o(osc_en_o), .bypass_o(bypass_o),
    .stable_o(stable_o), .err_o(err_o)
  );

  function automatic logic [15:0] word(input bit en, input bit byp, input int cnt);
    return {cnt[7:0], 6'd0, byp, en};
  endfunction

  function automatic bit exp_stable();
    return m_rdy | m_byp;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit wr, input logic [15:0] d, input bit tk);
    bit bad, kill, load;
    bad  = d[0] & d[1];
    kill = wr && !bad && !d[0];
    load = wr && !bad && d[0] && !m_en;
    if (wr && bad) m_err = 1'b1;
    if (wr && !bad) begin
      m_en  = d[0];
      m_byp = d[1];
    end
    if (kill) begin
      m_wait = 1'b0; m_rdy = 1'b0; m_left = 0;
    end else if (load) begin
      m_wait = 1'b1; m_rdy = 1'b0; m_left = int'(d[15:8]) * 8;
    end else if (m_wait && tk) begin
      if (m_left <= 1) begin m_wait = 1'b0; m_rdy = 1'b1; end
      if (m_left != 0) m_left--;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after comparing.
  task automatic step(input bit wr, input logic [15:0] d, input bit tk, input string tag);
    wr_en_i = wr; wr_data_i = d; slow_tick_i = tk;
    @(posedge clk);
    model(wr, d, tk);
    @(negedge clk);
    wr_en_i = 1'b0; slow_tick_i = 1'b0;
    check("R2 osc_en", osc_en_o, m_en);
    check("R2 bypass", bypass_o, m_byp);
    check("R8 err", err_o, m_err);
    check(tag, stable_o, exp_stable());
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 osc_en", osc_en_o, 1'b0);
    check("R1 bypass", bypass_o, 1'b0);
    check("R1 stable", stable_o, 1'b0);
    check("R1 err", err_o, 1'b0);

    // R3: count 1 -> 8 strobes; strobe in the load cycle is ignored
    step(1'b1, word(1, 0, 1), 1'b1, "R3 load-cycle strobe");
    ticks(7, "R3 waiting");
    step(1'b0, '0, 1'b1, "R3 eighth strobe");
    check("R3 stable after 8", stable_o, 1'b1);

    // R5: rewrite keeping enable does not restart
    step(1'b1, word(1, 0, 5), 1'b0, "R5 rewrite");
    check("R5 no restart", stable_o, 1'b1);

    // R6: disable colliding with a strobe
    step(1'b1, word(0, 0, 0), 1'b1, "R6 disable+strobe");
    check("R6 cleared", stable_o, 1'b0);

    // R4: count 0 -> first strobe
    step(1'b1, word(1, 0, 0), 1'b0, "R4 enable");
    check("R4 not yet", stable_o, 1'b0);
    // R10: no strobes, no progress
    for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b0, "R10 idle");
    check("R10 held low", stable_o, 1'b0);
    step(1'b0, '0, 1'b1, "R4 first strobe");
    check("R4 stable", stable_o, 1'b1);

    // R7: external clock with enable off
    step(1'b1, word(0, 1, 9), 1'b0, "R7 bypass");
    check("R7 stable now", stable_o, 1'b1);

    // R8: illegal write keeps previous state
    step(1'b1, word(1, 1, 3), 1'b1, "R8 illegal");
    check("R8 bypass kept", bypass_o, 1'b1);
    check("R8 enable kept", osc_en_o, 1'b0);
    check("R8 err set", err_o, 1'b1);

    // R8: illegal write during a wait leaves it running
    step(1'b1, word(0, 0, 0), 1'b0, "R6 off");
    step(1'b1, word(1, 0, 1), 1'b0, "R3 load");
    ticks(4, "R3 waiting");
    step(1'b1, word(1, 1, 0), 1'b1, "R8 illegal mid-wait");
    ticks(2, "R3 waiting");
    step(1'b0, '0, 1'b1, "R8 wait continued");
    check("R8 wait completed", stable_o, 1'b1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit wr, tk;
      logic [15:0] d;
      int c;
      wr = ($urandom % 12) == 0;
      tk = ($urandom % 3) == 0;
      c  = (($urandom % 8) == 0) ? int'($urandom % 256) : int'($urandom % 4);
      d  = word(bit'($urandom % 2), bit'(($urandom % 3) == 0), c);
      step(wr, d, tk, "R3 random stable");
    end

    // R9: error still held at the end
    check("R9 err sticky", err_o, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule